// File: doc/BRIEF.md
# Auxiliary-Switched Dual Register I/O Slave

This block is the slave side of a 4-bit I/O bus. Each bus cycle carries a 4-bit module address, a 4-bit data nibble and an IN (read) or OUT (write) strobe. Behind the bus sit several peripheral slots. Each slot has a primary register and an auxiliary register, and either register can be four or eight bits wide. A separate switch function has its own bus address.

A plain IN or OUT to a slot's address reaches that slot's primary register. To reach the auxiliary register, software first performs an OUT to the switch address, with the target slot's address as the data. The next access to that slot then goes to its auxiliary register. Once the whole width of that register has been transferred, accesses fall back to the primary register.

Eight-bit registers are moved as two consecutive nibble transfers to the same address, low nibble first. The register values are presented in parallel to the peripheral logic behind the slots.

Top module: `dsw_io_slave`

## Requirements
- R1: Slot i answers at address MOD_BASE+i (defaults: four slots at 4'h2..4'h5), and the switch answers at SW_ADDR (default 4'hE). By default the primary registers of slots 1 and 3 are 8 bits wide, as are the auxiliary registers of slots 1 and 2. All other registers are 4 bits wide, and their upper 4 bits read as zero on the parallel outputs.
- R2: With no steering pending for a slot, an OUT to that slot writes its primary register, and the new value appears on `pri_val` after the rising edge that samples the strobe. An IN returns the primary register's nibble on `io_rdata` in the same cycle.
- R3: An OUT to SW_ADDR whose data is a decoded slot address arms steering for that slot. That slot's next IN or OUT then reaches its auxiliary register, shown on `aux_val`.
- R4: An 8-bit register is accessed as two consecutive nibble transfers. The first transfer addresses bits [3:0] and the second addresses bits [7:4]. After the second transfer, the register's nibble pointer returns to low. Reads and writes share the same pointer.
- R5: Steering ends once the auxiliary register's full width has been transferred: after one access for a 4-bit register, or after the high-nibble access for an 8-bit register. Later accesses reach the primary register again.
- R6: While steering is pending for one slot, an access to another slot goes to that slot's primary register and leaves the pending steering unchanged.
- R7: Any OUT to SW_ADDR returns every nibble pointer to low.
- R8: An OUT to SW_ADDR whose data is not a decoded slot address cancels any pending steering.
- R9: `io_rdata` is 4'h0 when IN is low, and also during an IN to SW_ADDR or to any undecoded address.
- R10: When IN and OUT are asserted together, only the OUT is performed. `io_rdata` is 4'h0, and the read has no side effects on nibble pointers or steering.
- R11: Reset clears every register, the steering state and all nibble pointers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| io_addr | input | 4 | Module address of the current bus cycle |
| io_wdata | input | 4 | Write nibble |
| io_out | input | 1 | OUT (write) strobe |
| io_in | input | 1 | IN (read) strobe |
| io_rdata | output | 4 | Read nibble, combinational during IN |
| pri_val | output | NMOD*8 | Primary register values, slot i at bits [8i+7:8i] |
| aux_val | output | NMOD*8 | Auxiliary register values, slot i at bits [8i+7:8i] |

## Verification
Read data is combinational, so it is due in the same cycle as the IN strobe. The bench drives each bus cycle at a falling edge and samples `io_rdata` 2 ns later, well before the next rising edge. Register contents, nibble pointers and steering change at the rising edge that samples the strobe, so `pri_val` and `aux_val` are compared 1 ns after that edge. The effects of pointers and steering are observed through the read data of the next bus cycle. After reset is released, the synchronizer holds the internal state in reset for two more cycles, and the bench waits these out before its first bus cycle.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
  typedef logic [3:0] nib_t;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/dsw_rst_sync.sv
module dsw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = shreg[STAGES-1];
endmodule

// File: rtl/dsw_decode.sv
module dsw_decode
  import dsw_pkg::*;
#(
  parameter int   NMOD     = 4,
  parameter nib_t MOD_BASE = 4'h2,
  parameter nib_t SW_ADDR  = 4'hE
) (
  input  nib_t            addr,
  output logic [NMOD-1:0] mod_sel,
  output logic            sw_hit
);
  for (genvar i = 0; i < NMOD; i++) begin : g_slot
    localparam nib_t SLOT_ADDR = nib_t'(MOD_BASE + 4'(i));
    assign mod_sel[i] = (addr == SLOT_ADDR);
  end

  assign sw_hit = (addr == SW_ADDR);
endmodule

// File: rtl/dsw_steer.sv
module dsw_steer
  import dsw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic tgt_ok,
  input  nib_t tgt,
  input  logic clr,
  output logic vld,
  output nib_t addr
);
  logic vld_d;

  // Next-state: a switch write re-arms or cancels; otherwise a completed
  // auxiliary transfer drops the pending steer.
  always_comb begin
    vld_d = vld;
    if (arm)      vld_d = tgt_ok;
    else if (clr) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= 1'b0;
    else        vld <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   addr <= '0;
    else if (arm) addr <= tgt;
  end
endmodule

// File: rtl/dsw_nibreg.sv
module dsw_nibreg
  import dsw_pkg::*;
#(
  parameter bit IS_BYTE = 1'b0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  acc,
  input  logic  wr,
  input  logic  ptr_rst,
  input  nib_t  wdata,
  output byte_t q,
  output nib_t  rnib,
  output logic  last
);
  if (IS_BYTE) begin : g_byte
    logic  ptr, ptr_d;
    byte_t val, val_d;

    always_comb begin
      ptr_d = ptr;
      val_d = val;
      if (ptr_rst) begin
        ptr_d = 1'b0;
      end else if (acc) begin
        ptr_d = ~ptr;
        if (wr) begin
          if (ptr) val_d[7:4] = wdata;
          else     val_d[3:0] = wdata;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr <= 1'b0;
        val <= '0;
      end else begin
        ptr <= ptr_d;
        val <= val_d;
      end
    end

    assign q    = val;
    assign rnib = ptr ? val[7:4] : val[3:0];
    assign last = ptr;
  end else begin : g_nib
    nib_t val;
    logic ld;
    logic unused_ptr_rst;

    assign ld             = acc & wr;
    assign unused_ptr_rst = ptr_rst;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  val <= '0;
      else if (ld) val <= wdata;
    end

    assign q    = {4'h0, val};
    assign rnib = val;
    assign last = 1'b1;
  end
endmodule

// File: rtl/dsw_io_slave.sv
module dsw_io_slave
  import dsw_pkg::*;
#(
  parameter int              NMOD        = 4,
  parameter nib_t            MOD_BASE    = 4'h2,
  parameter nib_t            SW_ADDR     = 4'hE,
  parameter logic [NMOD-1:0] PRI_BYTE    = 4'b1010,
  parameter logic [NMOD-1:0] AUX_BYTE    = 4'b0110,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        io_addr,
  input  logic [3:0]        io_wdata,
  input  logic              io_out,
  input  logic              io_in,
  output logic [3:0]        io_rdata,
  output logic [NMOD*8-1:0] pri_val,
  output logic [NMOD*8-1:0] aux_val
);
  logic            rst_n_s;
  logic [NMOD-1:0] mod_sel, tgt_sel, clr_vec;
  logic            sw_hit, unused_tgt_sw;
  logic            wr_en, rd_en, acc_en, sw_wr, aux_route;
  logic            st_vld;
  nib_t            st_addr;
  nib_t            rd_vec [NMOD];

  dsw_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  dsw_decode #(.NMOD(NMOD), .MOD_BASE(MOD_BASE), .SW_ADDR(SW_ADDR)) u_dec_addr (
    .addr(io_addr), .mod_sel(mod_sel), .sw_hit(sw_hit)
  );

  dsw_decode #(.NMOD(NMOD), .MOD_BASE(MOD_BASE), .SW_ADDR(SW_ADDR)) u_dec_tgt (
    .addr(io_wdata), .mod_sel(tgt_sel), .sw_hit(unused_tgt_sw)
  );

  // OUT wins when both strobes are present.
  assign wr_en     = io_out;
  assign rd_en     = io_in & ~io_out;
  assign acc_en    = wr_en | rd_en;
  assign sw_wr     = wr_en & sw_hit;
  assign aux_route = st_vld & (st_addr == io_addr);

  for (genvar i = 0; i < NMOD; i++) begin : g_slot
    logic  acc_pri, acc_aux;
    byte_t pri_q, aux_q;
    nib_t  pri_rnib, aux_rnib;
    logic  pri_last, aux_last;

    assign acc_pri = acc_en & mod_sel[i] & ~aux_route;
    assign acc_aux = acc_en & mod_sel[i] &  aux_route;

    dsw_nibreg #(.IS_BYTE(PRI_BYTE[i])) u_pri (
      .clk(clk), .rst_n(rst_n_s), .acc(acc_pri), .wr(wr_en), .ptr_rst(sw_wr),
      .wdata(io_wdata), .q(pri_q), .rnib(pri_rnib), .last(pri_last)
    );

    dsw_nibreg #(.IS_BYTE(AUX_BYTE[i])) u_aux (
      .clk(clk), .rst_n(rst_n_s), .acc(acc_aux), .wr(wr_en), .ptr_rst(sw_wr),
      .wdata(io_wdata), .q(aux_q), .rnib(aux_rnib), .last(aux_last)
    );

    logic unused_pri_last;
    assign unused_pri_last = pri_last;

    assign clr_vec[i]         = acc_aux & aux_last;
    assign rd_vec[i]          = (rd_en & mod_sel[i]) ? (aux_route ? aux_rnib : pri_rnib) : 4'h0;
    assign pri_val[i*8 +: 8]  = pri_q;
    assign aux_val[i*8 +: 8]  = aux_q;
  end

  always_comb begin
    io_rdata = 4'h0;
    for (int i = 0; i < NMOD; i++) io_rdata = io_rdata | rd_vec[i];
  end

  dsw_steer u_steer (
    .clk(clk), .rst_n(rst_n_s), .arm(sw_wr), .tgt_ok(|tgt_sel), .tgt(io_wdata),
    .clr(|clr_vec), .vld(st_vld), .addr(st_addr)
  );
endmodule

// File: rtl/dsw_chk.sv
module dsw_chk #(
  parameter int         NMOD     = 4,
  parameter logic [3:0] MOD_BASE = 4'h2,
  parameter logic [3:0] SW_ADDR  = 4'hE
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic [3:0]        io_addr,
  input logic [3:0]        io_wdata,
  input logic              io_out,
  input logic              io_in,
  input logic [3:0]        io_rdata,
  input logic [NMOD*8-1:0] pri_val,
  input logic [NMOD*8-1:0] aux_val,
  input logic              st_vld,
  input logic [3:0]        st_addr
);
  logic [3:0] tgt_off;
  logic       tgt_in;
  logic       sw_out;

  assign tgt_off = io_wdata - MOD_BASE;
  assign tgt_in  = (32'(tgt_off) < NMOD);
  assign sw_out  = io_out && (io_addr == SW_ADDR);

  // R9
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !io_in |-> io_rdata == 4'h0);

  // R10
  both_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (io_in && io_out) |-> io_rdata == 4'h0);

  // R2
  pri_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !io_out |=> $stable(pri_val));

  // R5
  aux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (io_out && !(st_vld && st_addr == io_addr)) |=> $stable(aux_val));

  // R3
  arm_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sw_out && tgt_in) |=> (st_vld && st_addr == $past(io_wdata)));

  // R8
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sw_out && !tgt_in) |=> !st_vld);

  // R6
  keep_pending_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st_vld && (io_in || io_out) && io_addr != st_addr && io_addr != SW_ADDR)
      |=> (st_vld && $stable(st_addr)));
endmodule

bind dsw_io_slave dsw_chk #(.NMOD(NMOD), .MOD_BASE(MOD_BASE), .SW_ADDR(SW_ADDR)) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .io_addr(io_addr), .io_wdata(io_wdata),
  .io_out(io_out), .io_in(io_in), .io_rdata(io_rdata), .pri_val(pri_val),
  .aux_val(aux_val), .st_vld(st_vld), .st_addr(st_addr)
);

// File: tb/dsw_io_slave_test.sv
module dsw_io_slave_test;
  localparam int         NMOD     = 4;
  localparam logic [3:0] BASE     = 4'h2;
  localparam logic [3:0] SW       = 4'hE;
  localparam logic [3:0] PBYTE    = 4'b1010;
  localparam logic [3:0] ABYTE    = 4'b0110;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [3:0]        io_addr = 4'h0, io_wdata = 4'h0;
  logic              io_out = 1'b0, io_in = 1'b0;
  logic [3:0]        io_rdata;
  logic [NMOD*8-1:0] pri_val, aux_val;

  int tests = 0;
  int fails = 0;

  logic [7:0] m_pri [NMOD];
  logic [7:0] m_aux [NMOD];
  bit         m_pp  [NMOD];
  bit         m_ap  [NMOD];
  bit         m_v;
  logic [3:0] m_a;

  always #10 clk = ~clk;

  dsw_io_slave uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_out(io_out), .io_in(io_in), .io_rdata(io_rdata),
    .pri_val(pri_val), .aux_val(aux_val)
  );

  function automatic bit in_rng(logic [3:0] a);
    logic [3:0] off = a - BASE;
    return int'(off) < NMOD;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_state(string req);
    logic [NMOD*8-1:0] ep, ea;
    for (int i = 0; i < NMOD; i++) begin
      ep[i*8 +: 8] = m_pri[i];
      ea[i*8 +: 8] = m_aux[i];
    end
    check({req, " pri_val"}, 64'(pri_val), 64'(ep));
    check({req, " aux_val"}, 64'(aux_val), 64'(ea));
  endtask

  // One bus cycle; expected values follow the requirements.
  task automatic op(bit wr, bit rd, logic [3:0] a, logic [3:0] d, string req);
    logic [3:0] exp_rd = 4'h0;
    int  idx = int'(4'(a - BASE));
    bit  aux, isb, ptr;
    @(negedge clk);
    io_addr = a; io_wdata = d; io_out = wr; io_in = rd;
    if (in_rng(a)) begin
      aux = m_v && (m_a == a);
      isb = aux ? ABYTE[idx] : PBYTE[idx];
      ptr = aux ? m_ap[idx] : m_pp[idx];
      if (rd && !wr)
        exp_rd = aux ? (isb && ptr ? m_aux[idx][7:4] : m_aux[idx][3:0])
                     : (isb && ptr ? m_pri[idx][7:4] : m_pri[idx][3:0]);
    end
    #2;
    check({req, " rdata"}, 64'(io_rdata), 64'(exp_rd));
    @(posedge clk);
    #1;
    io_out = 1'b0; io_in = 1'b0;
    if (wr && a == SW) begin
      for (int i = 0; i < NMOD; i++) begin m_pp[i] = 0; m_ap[i] = 0; end
      m_v = in_rng(d);
      if (in_rng(d)) m_a = d;
    end else if ((wr || rd) && in_rng(a)) begin
      if (wr) begin
        if (aux) begin
          if (isb && ptr) m_aux[idx][7:4] = d; else m_aux[idx][3:0] = d;
        end else begin
          if (isb && ptr) m_pri[idx][7:4] = d; else m_pri[idx][3:0] = d;
        end
      end
      if (aux && (!isb || ptr)) m_v = 0;
      if (isb) begin
        if (aux) m_ap[idx] = !ptr; else m_pp[idx] = !ptr;
      end
    end
    check_state(req);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NMOD; i++) begin
      m_pri[i] = 0; m_aux[i] = 0; m_pp[i] = 0; m_ap[i] = 0;
    end
    m_v = 0; m_a = 0;
    repeat (3) @(posedge clk);
    #1;
    check_state("R11 reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 R9: read every address after reset
    for (int a = 0; a < 16; a++) op(0, 1, 4'(a), 4'h0, "R1 R9 R11 sweep read");

    // R2 R4: primary write/read sweep, two nibbles for byte slots
    for (int i = 0; i < NMOD; i++)
      for (int v = 0; v < 16; v++) begin
        op(1, 0, 4'(BASE + 4'(i)), 4'(v), "R2 R4 pri write");
        if (PBYTE[i]) op(1, 0, 4'(BASE + 4'(i)), 4'(v) ^ 4'hA, "R4 pri write hi");
        op(0, 1, 4'(BASE + 4'(i)), 4'h0, "R2 R4 pri read");
        if (PBYTE[i]) op(0, 1, 4'(BASE + 4'(i)), 4'h0, "R4 pri read hi");
      end

    // R3 R5: steered auxiliary writes, then fall back to primary
    for (int i = 0; i < NMOD; i++)
      for (int v = 0; v < 16; v++) begin
        op(1, 0, SW, 4'(BASE + 4'(i)), "R3 arm");
        op(1, 0, 4'(BASE + 4'(i)), 4'(15 - v), "R3 aux write");
        if (ABYTE[i]) op(1, 0, 4'(BASE + 4'(i)), 4'(v) ^ 4'h5, "R3 R4 aux write hi");
        op(0, 1, 4'(BASE + 4'(i)), 4'h0, "R5 back to pri");
        op(1, 0, SW, 4'(BASE + 4'(i)), "R3 arm read");
        op(0, 1, 4'(BASE + 4'(i)), 4'h0, "R3 aux read");
        if (ABYTE[i]) op(0, 1, 4'(BASE + 4'(i)), 4'h0, "R4 aux read hi");
        op(1, 0, 4'(BASE + 4'(i)), 4'(v), "R5 pri after aux");
      end

    // R6: pending steer on slot 1 survives access to slot 0 and slot 3
    op(1, 0, SW, BASE + 4'd1, "R6 arm");
    op(1, 0, BASE, 4'h7, "R6 other slot write");
    op(0, 1, BASE + 4'd3, 4'h0, "R6 other slot read");
    op(1, 0, BASE + 4'd1, 4'h3, "R6 aux lo");
    op(1, 0, BASE + 4'd1, 4'hC, "R6 aux hi");
    op(0, 1, BASE + 4'd1, 4'h0, "R6 R5 pri after");

    // R7: half-done byte transfer is reset by a switch write
    op(1, 0, BASE + 4'd3, 4'h9, "R7 pri lo");
    op(1, 0, SW, BASE, "R7 switch write");
    op(1, 0, BASE + 4'd3, 4'h4, "R7 pri lo again");
    op(1, 0, BASE, 4'h6, "R7 pending still on slot0");
    op(0, 1, BASE + 4'd3, 4'h0, "R7 read ptr");

    // R8: undecoded switch target cancels steering
    op(1, 0, SW, BASE + 4'd2, "R8 arm");
    op(1, 0, SW, 4'h9, "R8 cancel");
    op(1, 0, BASE + 4'd2, 4'hB, "R8 goes to pri");
    op(1, 0, SW, BASE + 4'd2, "R8 re-arm");
    op(1, 0, SW, SW, "R8 cancel with sw addr");
    op(0, 1, BASE + 4'd2, 4'h0, "R8 read pri");

    // R10: both strobes
    op(1, 0, SW, BASE + 4'd1, "R10 arm");
    op(1, 1, BASE + 4'd1, 4'hD, "R10 both strobes");
    op(1, 1, BASE + 4'd1, 4'h2, "R10 both strobes hi");
    op(0, 1, BASE + 4'd1, 4'h0, "R10 pri read");
    op(1, 1, 4'h0, 4'h1, "R10 undecoded both");
    op(0, 1, SW, 4'h0, "R9 switch read");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule